// File: doc/BRIEF.md
# Scan-Skipping Sample Stream Filter

This block sits between the drain port of an acquisition FIFO and a downstream sample consumer. A converter that runs a multi-channel scan at a fixed conversion rate keeps producing samples even when the wanted scan period is a whole multiple of one burst of channels. The filter treats the stream as repeating chunks. Each chunk holds `scan_len * (1 + skip)` samples. The first `scan_len` samples of a chunk go downstream and the rest are consumed and discarded. The software side derives the skip factor as the scan period divided by (conversion period times scan length), minus one. A scan period that is not a whole multiple is rounded down to one, and the smallest allowed scan period is that product itself.

Every forwarded raw word is recoded to an offset-binary code of `DATA_W` bits. A stop counter runs down once per consumed sample, whether that sample is forwarded or dropped. In counted mode the filter raises `done` when the counter reaches zero and then refuses further input. In continuous mode it never stops. A one-cycle `start` pulse does three things: it latches the configuration, clears the chunk position and reloads the counter.

Both streams use valid/ready handshakes, with a combinational path through the block and no buffering. A sample transfers on a clock edge where `in_valid` and `in_ready` are both high. For a sample that will be forwarded, `out_valid` follows `in_valid` and `in_ready` follows `out_ready`, so back-pressure passes straight upstream. A sample that will be dropped is accepted whatever the state of `out_ready`, and `out_valid` stays low for it. The upstream must hold `in_data` steady while `in_valid` is high and the sample has not been taken.

Top module: `scan_decimator`

## Requirements
- R1: After reset and before the first `start`, `in_ready`, `out_valid` and `done` are all low.
- R2: `out_data` is the raw word shifted right by `RAW_W-DATA_W` bits, masked to `DATA_W` bits and XORed with the mid-scale value `1<<(DATA_W-1)`. With a 16-bit raw word and a 12-bit result, this is raw bits 15:4 with the top bit inverted.
- R3: A chunk is `scan_len*(1+skip)` consumed samples long. The first `scan_len` samples of each chunk are forwarded in order. The rest are consumed without appearing on the output.
- R4: The position within a chunk wraps to zero after the last sample of the chunk, so forwarding resumes with the next sample. This holds up to the largest skip factor.
- R5: With `skip` = 0, every consumed sample is forwarded.
- R6: While a sample that will be forwarded is offered, `in_ready` equals `out_ready`. A sample that will be dropped is accepted even when `out_ready` is low.
- R7: In counted mode (`continuous` = 0 at start), the counter is loaded with `scan_count*scan_len*(1+skip)` and counts every consumed sample. After the last one, `done` goes high and stays high, and `in_ready` and `out_valid` stay low until the next `start`.
- R8: In continuous mode (`continuous` = 1 at start), `done` never rises and samples are accepted indefinitely.
- R9: While `start` is high, no sample is accepted. A `start` issued in the middle of a run clears the chunk position, reloads the counter and clears `done`.
- R10: `scan_len`, `skip`, `scan_count` and `continuous` are sampled only on `start`. Changing them during a run has no effect on forwarding, dropping or the stop point.
- R11: A counted start with `scan_count` = 0 raises `done` in the next cycle, and no sample is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Latch configuration, clear position, reload counter |
| continuous | input | 1 | 1 = run without a stop count |
| scan_len | input | LEN_W | Channels per scan |
| skip | input | SKIP_W | Scans discarded after each forwarded scan |
| scan_count | input | CNT_W | Scans to acquire in counted mode |
| in_valid | input | 1 | Raw sample offered |
| in_ready | output | 1 | Raw sample taken on this edge |
| in_data | input | RAW_W | Raw converter word |
| out_valid | output | 1 | Recoded sample offered |
| out_ready | input | 1 | Downstream takes the sample |
| out_data | output | DATA_W | Offset-binary sample |
| done | output | 1 | Counted acquisition complete |

## Verification
The bench builds the filter with a 16-bit raw word and a 12-bit result, so the shift-and-invert recoding path is the one exercised. It uses a 4-bit skip field and an 8-bit scan count. With these narrow widths, the largest skip factor of 15 gives a 16-sample chunk, so several position wraps at the top of the skip range fit in a short run. Counted runs also end within a few dozen samples, so the stop point, the refusal after `done`, restarts mid-chunk and configuration changes during a run can all be tested in turn.

// File: rtl/scan_skip_pkg.sv
package scan_skip_pkg;
  typedef enum logic {
    RUN_COUNTED = 1'b0,
    RUN_FREE    = 1'b1
  } run_mode_e;
endpackage

// File: rtl/sample_recode.sv
module sample_recode #(
  parameter int RAW_W  = 16,
  parameter int DATA_W = 12
) (
  input  logic [RAW_W-1:0]  raw,
  output logic [DATA_W-1:0] code
);
  localparam int SHIFT = RAW_W - DATA_W;
  localparam logic [DATA_W-1:0] MID = DATA_W'(1) << (DATA_W - 1);

  generate
    if (SHIFT == 0) begin : g_direct
      assign code = raw ^ MID;
    end else begin : g_shifted
      assign code = raw[RAW_W-1 -: DATA_W] ^ MID;
    end
  endgenerate
endmodule

// File: rtl/chunk_gate.sv
module chunk_gate #(
  parameter int LEN_W  = 5,
  parameter int SKIP_W = 8,
  localparam int CHUNK_W = LEN_W + SKIP_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               advance,
  input  logic [LEN_W-1:0]   len,
  input  logic [SKIP_W-1:0]  skip,
  output logic               keep,
  output logic               bypass,
  output logic [CHUNK_W-1:0] pos,
  output logic [CHUNK_W-1:0] chunk_len
);
  logic [CHUNK_W-1:0] pos_inc;

  assign chunk_len = CHUNK_W'(len) * (CHUNK_W'(skip) + CHUNK_W'(1));
  assign bypass    = (skip == '0);
  assign keep      = bypass || (pos < CHUNK_W'(len));
  assign pos_inc   = pos + CHUNK_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos <= '0;
    end else if (clear) begin
      pos <= '0;
    end else if (advance && !bypass) begin
      pos <= (pos_inc == chunk_len) ? '0 : pos_inc;
    end
  end
endmodule

// File: rtl/acq_countdown.sv
module acq_countdown #(
  parameter int W = 29
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);
  logic [W-1:0] remain;

  assign zero = (remain == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
    end else if (load) begin
      remain <= load_val;
    end else if (dec && !zero) begin
      remain <= remain - W'(1);
    end
  end
endmodule

// File: rtl/scan_decimator.sv
module scan_decimator
  import scan_skip_pkg::*;
#(
  parameter int RAW_W  = 16,
  parameter int DATA_W = 12,
  parameter int LEN_W  = 5,
  parameter int SKIP_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              continuous,
  input  logic [LEN_W-1:0]  scan_len,
  input  logic [SKIP_W-1:0] skip,
  input  logic [CNT_W-1:0]  scan_count,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [RAW_W-1:0]  in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              done
);
  localparam int CHUNK_W = LEN_W + SKIP_W + 1;
  localparam int STOP_W  = CNT_W + CHUNK_W;

  logic [LEN_W-1:0]   len_q;
  logic [SKIP_W-1:0]  skip_q;
  run_mode_e          mode_q;
  logic               running_q;
  logic               keep;
  logic               skip_zero;
  logic               cnt_zero;
  logic               accept_ok;
  logic               fire;
  logic [CHUNK_W-1:0] pos_w;
  logic [CHUNK_W-1:0] chunk_len_w;
  logic [STOP_W-1:0]  load_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q     <= '0;
      skip_q    <= '0;
      mode_q    <= RUN_COUNTED;
      running_q <= 1'b0;
    end else if (start) begin
      len_q     <= scan_len;
      skip_q    <= skip;
      mode_q    <= continuous ? RUN_FREE : RUN_COUNTED;
      running_q <= 1'b1;
    end
  end

  assign load_val = STOP_W'(scan_count) * STOP_W'(scan_len)
                  * (STOP_W'(skip) + STOP_W'(1));

  assign done      = running_q && (mode_q == RUN_COUNTED) && cnt_zero;
  assign accept_ok = running_q && !start && !done;
  assign out_valid = in_valid && accept_ok && keep;
  assign in_ready  = accept_ok && (!keep || out_ready);
  assign fire      = in_valid && in_ready;

  chunk_gate #(
    .LEN_W  (LEN_W),
    .SKIP_W (SKIP_W)
  ) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (start),
    .advance   (fire),
    .len       (len_q),
    .skip      (skip_q),
    .keep      (keep),
    .bypass    (skip_zero),
    .pos       (pos_w),
    .chunk_len (chunk_len_w)
  );

  acq_countdown #(
    .W (STOP_W)
  ) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start),
    .load_val (load_val),
    .dec      (fire && (mode_q == RUN_COUNTED)),
    .zero     (cnt_zero)
  );

  sample_recode #(
    .RAW_W  (RAW_W),
    .DATA_W (DATA_W)
  ) u_recode (
    .raw  (in_data),
    .code (out_data)
  );
endmodule

// File: rtl/scan_decimator_chk.sv
module scan_decimator_chk #(
  parameter int CHUNK_W = 14
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               in_valid,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic               done,
  input logic               running,
  input logic               free_run,
  input logic               skip_zero,
  input logic [CHUNK_W-1:0] pos,
  input logic [CHUNK_W-1:0] chunk_len
);
  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !in_ready && !out_valid && !done);

  p_out_needs_in_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_valid);

  p_pos_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !skip_zero) |-> (pos < chunk_len));

  p_ready_link_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (in_ready == out_ready));

  p_done_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !in_ready && !out_valid);

  p_done_sticks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  p_free_never_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    free_run |-> !done);

  p_start_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !in_ready);
endmodule

bind scan_decimator scan_decimator_chk #(
  .CHUNK_W (CHUNK_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .done      (done),
  .running   (running_q),
  .free_run  (mode_q == scan_skip_pkg::RUN_FREE),
  .skip_zero (skip_zero),
  .pos       (pos_w),
  .chunk_len (chunk_len_w)
);

// File: tb/test_scan_decimator.sv
module test_scan_decimator;
  localparam int RAW_W  = 16;
  localparam int DATA_W = 12;
  localparam int LEN_W  = 5;
  localparam int SKIP_W = 4;
  localparam int CNT_W  = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic              continuous = 1'b0;
  logic [LEN_W-1:0]  scan_len = '0;
  logic [SKIP_W-1:0] skip = '0;
  logic [CNT_W-1:0]  scan_count = '0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [RAW_W-1:0]  in_data = '0;
  logic              out_valid;
  logic              out_ready = 1'b0;
  logic [DATA_W-1:0] out_data;
  logic              done;

  int checks = 0;
  int errors = 0;
  logic [DATA_W-1:0] exp_q[$];

  // reference model state
  int m_len, m_skip, m_pos, m_rem;
  bit m_free, m_run;

  always #5 clk = ~clk;

  scan_decimator #(
    .RAW_W(RAW_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .SKIP_W(SKIP_W), .CNT_W(CNT_W)
  ) i_scan_decimator (
    .clk(clk), .rst_n(rst_n), .start(start), .continuous(continuous),
    .scan_len(scan_len), .skip(skip), .scan_count(scan_count),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .done(done)
  );

  function automatic logic [DATA_W-1:0] recode(logic [RAW_W-1:0] r);
    return (DATA_W'(r >> (RAW_W - DATA_W))) ^ (DATA_W'(1) << (DATA_W - 1));
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // R9: start pulse with a sample offered; model latches config
  task automatic do_start(int len, int sk, int cnt, bit free_mode);
    @(negedge clk);
    scan_len = LEN_W'(len); skip = SKIP_W'(sk);
    scan_count = CNT_W'(cnt); continuous = free_mode;
    start = 1'b1; in_valid = 1'b1; in_data = 16'h1234; out_ready = 1'b1;
    #2;
    check(in_ready == 1'b0, "R9 start blocks input", in_ready, 0);
    m_len = len; m_skip = sk; m_pos = 0; m_free = free_mode; m_run = 1;
    m_rem = cnt * len * (sk + 1);
    @(negedge clk);
    start = 1'b0; in_valid = 1'b0;
  endtask

  // driver: offers n samples, predicts readiness, pushes expected outputs
  task automatic drive(int n, bit bp);
    for (int i = 0; i < n; i++) begin
      bit keep, m_done, exp_rdy;
      @(negedge clk);
      in_valid = 1'b1;
      in_data = RAW_W'($urandom);
      out_ready = bp ? ($urandom_range(0, 2) != 0) : 1'b1;
      #2;
      keep = (m_skip == 0) || (m_pos < m_len);
      m_done = m_run && !m_free && (m_rem == 0);
      exp_rdy = m_run && !m_done && (!keep || out_ready);
      check(in_ready == exp_rdy, "R6 R3 R7 in_ready", in_ready, exp_rdy);
      if (in_ready && exp_rdy) begin
        if (keep) exp_q.push_back(recode(in_data));
        if (m_skip != 0) m_pos = (m_pos + 1 == m_len * (m_skip + 1)) ? 0 : m_pos + 1;
        if (!m_free && m_rem > 0) m_rem--;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor: compares each output transfer with the scoreboard (R2, R3, R4, R5)
  always @(negedge clk) begin
    #3;
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R3 unexpected output", int'(out_data), -1);
      end else begin
        logic [DATA_W-1:0] e;
        e = exp_q.pop_front();
        check(out_data == e, "R2 R3 output word", int'(out_data), int'(e));
      end
    end
  end

  task automatic end_of_run(string req);
    bit m_done;
    @(negedge clk); #3;
    m_done = m_run && !m_free && (m_rem == 0);
    check(done == m_done, req, done, m_done);
    check(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    m_run = 0; m_free = 0; m_len = 1; m_skip = 0; m_pos = 0; m_rem = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: idle before any start, even with a sample offered
    @(negedge clk);
    in_valid = 1'b1; out_ready = 1'b1; #2;
    check(in_ready == 1'b0, "R1 in_ready idle", in_ready, 0);
    check(out_valid == 1'b0, "R1 out_valid idle", out_valid, 0);
    check(done == 1'b0, "R1 done idle", done, 0);
    @(negedge clk); in_valid = 1'b0;

    // R5 R7: no skip, 4 scans of 3, extra offers refused after done
    do_start(3, 0, 4, 1'b0);
    drive(15, 1'b0);
    end_of_run("R7 done after 12 samples");

    // R3 R4 R6: 2 kept of each 6, back-pressure
    do_start(2, 2, 3, 1'b0);
    drive(30, 1'b1);
    end_of_run("R7 done after 18 samples");

    // R8: continuous, far beyond any count
    do_start(4, 1, 1, 1'b1);
    drive(40, 1'b1);
    end_of_run("R8 never done");

    // R10: change inputs during the run
    do_start(2, 1, 2, 1'b0);
    @(negedge clk);
    scan_len = 5'd5; skip = 4'd0; scan_count = 8'd1; continuous = 1'b1;
    drive(12, 1'b0);
    end_of_run("R10 latched config stop point");

    // R9: restart in the middle of a chunk
    do_start(3, 2, 2, 1'b0);
    drive(4, 1'b0);
    do_start(3, 2, 2, 1'b0);
    drive(20, 1'b1);
    end_of_run("R9 restart reload");

    // R9: restart after done clears done
    do_start(1, 1, 1, 1'b0);
    drive(2, 1'b0);
    end_of_run("R7 short run done");

    // R11: zero count in counted mode
    do_start(2, 1, 0, 1'b0);
    drive(3, 1'b0);
    end_of_run("R11 zero count done");

    // R4: largest skip factor, chunk of 16
    do_start(1, 15, 3, 1'b0);
    drive(50, 1'b1);
    end_of_run("R4 wrap at max skip");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule